// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block implements the exception-entry path of a 64-bit processor's system-control unit. An exception request arrives as a single-cycle pulse. The pulse carries a 5-bit cause code, a coprocessor number, the PC of the instruction at the head of the pipe, a delay-slot flag, a refill-invalid flag for TLB misses and the faulting virtual address.

On the next clock edge the unit does the following:
- sets the exception-level bit;
- records the coprocessor number and the cause code;
- captures the return address and the delay-slot indication, but only if the exception level was clear beforehand;
- pulses a redirect strobe together with the sign-extended handler address.

An interrupt-acceptance gate raises the same kind of entry for pending, enabled interrupts. It uses cause code 0 and coprocessor 0. Bootstrap vectoring is not supported. A request made while the bootstrap-vector bit is set, or a request with an unknown code, produces an error pulse instead of an entry. The fetch stage uses the redirect strobe and vector to restart at the handler. The exception-return logic clears the exception level through a dedicated input.

Top module: `exc_entry_unit`

## Requirements
- R1: `irq_accept_o` is 1 exactly when `(int_mask_i & int_pending_i)` is nonzero, `int_enable_i` is 1, the exception level is 0 and `err_level_i` is 0.
- R2: An accepted interrupt with no explicit request enters with code 0 and coprocessor 0. An explicit request in the same cycle takes priority and its own code and coprocessor are recorded.
- R3: Every accepted entry sets `exl_o` to 1 and loads `ce_o` and `exc_code_o`. It also pulses `redirect_o` high for exactly one cycle. All of these appear on the clock edge that samples the request.
- R4: If the exception level was 0 before the entry, a delay-slot request gives `bd_o`=1 and `epc_o`=PC-4. A request outside a delay slot gives `bd_o`=0 and `epc_o`=PC.
- R5: If the exception level was already 1, an entry leaves `epc_o` and `bd_o` unchanged.
- R6: Codes 0, 1, 4 to 13, 15 and 23 vector to 0xFFFFFFFF80000180.
- R7: Codes 2 and 3 (TLB load/store miss) vector to 0xFFFFFFFF80000180 when the old exception level was 1 or `tlb_refill_invalid_i` is 1. Otherwise they vector to 0xFFFFFFFF80000080 in 64-bit mode and to 0xFFFFFFFF80000000 in 32-bit mode.
- R8: 64-bit mode is taken from `bad_vaddr_i[63:62]`: 00 selects `user_wide_i`, 01 selects `super_wide_i` and 11 selects `kernel_wide_i`. The value 10 always means 32-bit mode.
- R9: A request with a code outside R6/R7 (such as 14), or any request while `boot_vec_i` is 1, pulses `err_o` for one cycle one edge later. In that case there is no redirect and EXL, BD, CE, code, EPC and vector are unchanged.
- R10: `exl_clr_i` clears the exception level on the next edge. An entry in the same cycle wins and leaves it at 1.
- R11: A synchronous reset clears EXL, BD, CE, code, EPC, vector, redirect and error outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req_i | input | 1 | Explicit exception request pulse |
| exc_code_i | input | 5 | Cause code of the request |
| exc_cop_i | input | 2 | Coprocessor number of the request |
| exc_pc_i | input | 64 | PC of the faulting or interrupted instruction |
| exc_in_delay_i | input | 1 | Instruction sits in a branch delay slot |
| tlb_refill_invalid_i | input | 1 | TLB miss hit an invalid entry rather than a missing one |
| bad_vaddr_i | input | 64 | Faulting virtual address |
| int_pending_i | input | 8 | Interrupt pending lines |
| int_mask_i | input | 8 | Interrupt mask |
| int_enable_i | input | 1 | Global interrupt enable |
| err_level_i | input | 1 | Error-level bit |
| boot_vec_i | input | 1 | Bootstrap-vector bit (unsupported) |
| user_wide_i | input | 1 | 64-bit addressing for user region |
| super_wide_i | input | 1 | 64-bit addressing for supervisor region |
| kernel_wide_i | input | 1 | 64-bit addressing for kernel region |
| exl_clr_i | input | 1 | Exception return: clear the exception level |
| irq_accept_o | output | 1 | Interrupt gate open (combinational) |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| vector_o | output | 64 | Handler address of the last entry |
| epc_o | output | 64 | Exception return address |
| exl_o | output | 1 | Exception level |
| bd_o | output | 1 | Entry came from a delay slot |
| ce_o | output | 2 | Recorded coprocessor number |
| exc_code_o | output | 5 | Recorded cause code |
| err_o | output | 1 | Unsupported request pulse |

## Verification
`irq_accept_o` is combinational. It is compared a few time units after the inputs change in the low clock phase, before the next rising edge. Every registered result is due one edge after the request is driven: redirect, error, EXL, BD, CE, code, EPC and vector. The bench drives on a falling edge and samples at the following falling edge, so each registered check lands exactly one register stage after its stimulus. The bench also re-checks the next cycle to confirm that the strobes fall back to 0 and that the recorded state holds.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN   = 64;
    localparam int CODE_W = 5;
    localparam int COP_W  = 2;
    localparam int INT_W  = 8;

    typedef enum logic [CODE_W-1:0] {
        EC_INT     = 5'd0,
        EC_MOD     = 5'd1,
        EC_TLB_LD  = 5'd2,
        EC_TLB_ST  = 5'd3,
        EC_ADDR_LD = 5'd4,
        EC_ADDR_ST = 5'd5,
        EC_IBUS    = 5'd6,
        EC_DBUS    = 5'd7,
        EC_SYS     = 5'd8,
        EC_BRK     = 5'd9,
        EC_RSVD    = 5'd10,
        EC_COPU    = 5'd11,
        EC_OVF     = 5'd12,
        EC_TRAP    = 5'd13,
        EC_FPE     = 5'd15,
        EC_WATCH   = 5'd23
    } exc_code_e;

    // low 32 bits of the handler entry points; upper half is sign fill
    localparam logic [31:0] VEC_GENERAL = 32'h8000_0180;
    localparam logic [31:0] VEC_MISS_64 = 32'h8000_0080;
    localparam logic [31:0] VEC_MISS_32 = 32'h8000_0000;

    function automatic logic [XLEN-1:0] sext32(input logic [31:0] v);
        return {{(XLEN-32){v[31]}}, v};
    endfunction

    function automatic logic is_tlb_miss(input logic [CODE_W-1:0] c);
        return (c == EC_TLB_LD) || (c == EC_TLB_ST);
    endfunction

    function automatic logic code_general(input logic [CODE_W-1:0] c);
        logic r;
        case (c)
            EC_INT, EC_MOD, EC_ADDR_LD, EC_ADDR_ST, EC_IBUS, EC_DBUS,
            EC_SYS, EC_BRK, EC_RSVD, EC_COPU, EC_OVF, EC_TRAP,
            EC_FPE, EC_WATCH: r = 1'b1;
            default:          r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic code_known(input logic [CODE_W-1:0] c);
        return code_general(c) || is_tlb_miss(c);
    endfunction

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int INT_W = exc_pkg::INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] pending_i,
    input  logic [INT_W-1:0] mask_i,
    input  logic             ie_i,
    input  logic             exl_i,
    input  logic             erl_i,
    output logic             accept_o
);

    logic [INT_W-1:0] live;
    logic             any_live;

    always_comb begin
        live     = pending_i & mask_i;
        any_live = |live;
        accept_o = any_live && ie_i && !exl_i && !erl_i;
    end

    // R1: no acceptance while already at exception level
    p_gate_closed_r1: assert property (@(posedge clk) disable iff (rst)
        exl_i |-> !accept_o);

endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
    parameter int XLEN = exc_pkg::XLEN
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            in_delay_i,
    input  logic            old_exl_i,
    input  logic [XLEN-1:0] epc_cur_i,
    input  logic            bd_cur_i,
    output logic [XLEN-1:0] epc_o,
    output logic            bd_o
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    always_comb begin
        epc_o = epc_cur_i;
        bd_o  = bd_cur_i;
        if (!old_exl_i) begin
            bd_o  = in_delay_i;
            epc_o = in_delay_i ? (pc_i - INSN_BYTES) : pc_i;
        end
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int XLEN   = exc_pkg::XLEN,
    parameter int CODE_W = exc_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              old_exl_i,
    input  logic              refill_invalid_i,
    input  logic [1:0]        region_i,
    input  logic              user_wide_i,
    input  logic              super_wide_i,
    input  logic              kernel_wide_i,
    output logic [XLEN-1:0]   vector_o
);
    import exc_pkg::*;

    logic wide_mode;
    logic miss;

    always_comb begin
        case (region_i)
            2'b00:   wide_mode = user_wide_i;
            2'b01:   wide_mode = super_wide_i;
            2'b11:   wide_mode = kernel_wide_i;
            default: wide_mode = 1'b0;
        endcase
    end

    always_comb begin
        miss     = is_tlb_miss(code_i);
        vector_o = sext32(VEC_GENERAL);
        if (miss && !old_exl_i && !refill_invalid_i) begin
            vector_o = wide_mode ? sext32(VEC_MISS_64) : sext32(VEC_MISS_32);
        end
    end

    // R8: region 10 never yields the wide refill entry
    p_region_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        (region_i == 2'b10) |-> (vector_o != sext32(VEC_MISS_64)));

    // R6: non-miss codes always take the general entry
    p_general_entry_r6: assert property (@(posedge clk) disable iff (rst)
        !miss |-> (vector_o[11:0] == 12'h180));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
    parameter int XLEN   = exc_pkg::XLEN,
    parameter int CODE_W = exc_pkg::CODE_W,
    parameter int COP_W  = exc_pkg::COP_W,
    parameter int INT_W  = exc_pkg::INT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [COP_W-1:0]  exc_cop_i,
    input  logic [XLEN-1:0]   exc_pc_i,
    input  logic              exc_in_delay_i,
    input  logic              tlb_refill_invalid_i,
    input  logic [XLEN-1:0]   bad_vaddr_i,
    input  logic [INT_W-1:0]  int_pending_i,
    input  logic [INT_W-1:0]  int_mask_i,
    input  logic              int_enable_i,
    input  logic              err_level_i,
    input  logic              boot_vec_i,
    input  logic              user_wide_i,
    input  logic              super_wide_i,
    input  logic              kernel_wide_i,
    input  logic              exl_clr_i,
    output logic              irq_accept_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   vector_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              exl_o,
    output logic              bd_o,
    output logic [COP_W-1:0]  ce_o,
    output logic [CODE_W-1:0] exc_code_o,
    output logic              err_o
);
    import exc_pkg::*;

    typedef struct packed {
        logic              exl;
        logic              bd;
        logic [COP_W-1:0]  ce;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   vec;
        logic              redirect;
        logic              err;
    } entry_state_t;

    entry_state_t st_d, st_q;

    logic              irq_ok;
    logic              take;
    logic              reject;
    logic [CODE_W-1:0] sel_code;
    logic [COP_W-1:0]  sel_cop;
    logic [XLEN-1:0]   epc_next;
    logic              bd_next;
    logic [XLEN-1:0]   vec_next;
    logic              unused_vaddr_low;

    assign unused_vaddr_low = ^bad_vaddr_i[XLEN-3:0];

    exc_irq_gate #(.INT_W(INT_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .pending_i (int_pending_i),
        .mask_i    (int_mask_i),
        .ie_i      (int_enable_i),
        .exl_i     (st_q.exl),
        .erl_i     (err_level_i),
        .accept_o  (irq_ok)
    );

    // explicit request has priority over the interrupt gate
    always_comb begin
        take     = exc_req_i || irq_ok;
        sel_code = exc_req_i ? exc_code_i : CODE_W'(EC_INT);
        sel_cop  = exc_req_i ? exc_cop_i  : '0;
        reject   = boot_vec_i || !code_known(sel_code);
    end

    exc_epc_calc #(.XLEN(XLEN)) u_epc (
        .pc_i       (exc_pc_i),
        .in_delay_i (exc_in_delay_i),
        .old_exl_i  (st_q.exl),
        .epc_cur_i  (st_q.epc),
        .bd_cur_i   (st_q.bd),
        .epc_o      (epc_next),
        .bd_o       (bd_next)
    );

    exc_vector_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vsel (
        .clk              (clk),
        .rst              (rst),
        .code_i           (sel_code),
        .old_exl_i        (st_q.exl),
        .refill_invalid_i (tlb_refill_invalid_i),
        .region_i         (bad_vaddr_i[XLEN-1 -: 2]),
        .user_wide_i      (user_wide_i),
        .super_wide_i     (super_wide_i),
        .kernel_wide_i    (kernel_wide_i),
        .vector_o         (vec_next)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.err      = 1'b0;
        if (exl_clr_i) begin
            st_d.exl = 1'b0;
        end
        if (take) begin
            if (reject) begin
                st_d.err = 1'b1;
            end else begin
                st_d.exl      = 1'b1;
                st_d.bd       = bd_next;
                st_d.epc      = epc_next;
                st_d.ce       = sel_cop;
                st_d.code     = sel_code;
                st_d.vec      = vec_next;
                st_d.redirect = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_accept_o = irq_ok;
    assign redirect_o   = st_q.redirect;
    assign vector_o     = st_q.vec;
    assign epc_o        = st_q.epc;
    assign exl_o        = st_q.exl;
    assign bd_o         = st_q.bd;
    assign ce_o         = st_q.ce;
    assign exc_code_o   = st_q.code;
    assign err_o        = st_q.err;

    // R3: a redirect always comes with the exception level raised
    p_exl_on_redirect_r3: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> exl_o);

    // R3: redirect and error never appear together
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(redirect_o && err_o));

    // R5: nested entry keeps the saved return address
    p_epc_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && exl_o) |=> ($stable(epc_o) && $stable(bd_o)));

    // R2: a lone interrupt records code 0 and coprocessor 0
    p_irq_code_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_accept_o && !exc_req_i && !boot_vec_i) |=>
            (redirect_o && exc_code_o == '0 && ce_o == '0));

    // R9: bootstrap-vector requests only raise the error pulse
    p_boot_err_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && boot_vec_i) |=> (err_o && !redirect_o));

    // R4: a first-level delay-slot entry marks BD
    p_bd_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && exc_in_delay_i && !exl_o && !boot_vec_i
         && code_known(exc_code_i)) |=> bd_o);

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req_i;
    logic [4:0]  exc_code_i;
    logic [1:0]  exc_cop_i;
    logic [63:0] exc_pc_i;
    logic        exc_in_delay_i;
    logic        tlb_refill_invalid_i;
    logic [63:0] bad_vaddr_i;
    logic [7:0]  int_pending_i;
    logic [7:0]  int_mask_i;
    logic        int_enable_i;
    logic        err_level_i;
    logic        boot_vec_i;
    logic        user_wide_i;
    logic        super_wide_i;
    logic        kernel_wide_i;
    logic        exl_clr_i;
    logic        irq_accept_o;
    logic        redirect_o;
    logic [63:0] vector_o;
    logic [63:0] epc_o;
    logic        exl_o;
    logic        bd_o;
    logic [1:0]  ce_o;
    logic [4:0]  exc_code_o;
    logic        err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit dut_i (.*);

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // reference state
    logic        m_exl, m_bd, m_red, m_err;
    logic [1:0]  m_ce;
    logic [4:0]  m_code;
    logic [63:0] m_epc, m_vec;

    function automatic logic f_known(input logic [4:0] c);
        return (c <= 5'd13) || (c == 5'd15) || (c == 5'd23);
    endfunction

    function automatic logic [63:0] f_vec(input logic [4:0] c, input logic oexl,
                                          input logic inv, input logic [63:0] va,
                                          input logic u, input logic s, input logic k);
        logic wide;
        if (!(c == 5'd2 || c == 5'd3) || oexl || inv) return 64'hFFFF_FFFF_8000_0180;
        case (va[63:62])
            2'b00: wide = u;
            2'b01: wide = s;
            2'b11: wide = k;
            default: wide = 1'b0;
        endcase
        return wide ? 64'hFFFF_FFFF_8000_0080 : 64'hFFFF_FFFF_8000_0000;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_exl = 0; m_bd = 0; m_red = 0; m_err = 0;
        m_ce = 0; m_code = 0; m_epc = 0; m_vec = 0;
    endtask

    task automatic check_state(input string tag);
        chk(tag, "redirect", 64'(redirect_o), 64'(m_red));
        chk(tag, "err",      64'(err_o),      64'(m_err));
        chk(tag, "exl",      64'(exl_o),      64'(m_exl));
        chk(tag, "bd",       64'(bd_o),       64'(m_bd));
        chk(tag, "ce",       64'(ce_o),       64'(m_ce));
        chk(tag, "code",     64'(exc_code_o), 64'(m_code));
        chk(tag, "epc",      epc_o,           m_epc);
        chk(tag, "vector",   vector_o,        m_vec);
    endtask

    // called at a falling edge with inputs already driven
    task automatic run_cycle(input string tag);
        logic gate, take, oexl;
        logic [4:0] c;
        logic [1:0] cp;
        #1;
        oexl = m_exl;
        gate = (|(int_mask_i & int_pending_i)) && int_enable_i && !oexl && !err_level_i;
        chk("R1", "irq_accept", 64'(irq_accept_o), 64'(gate));
        take = exc_req_i || gate;
        c    = exc_req_i ? exc_code_i : 5'd0;
        cp   = exc_req_i ? exc_cop_i  : 2'd0;
        m_red = 0; m_err = 0;
        if (exl_clr_i) m_exl = 0;
        if (take) begin
            if (boot_vec_i || !f_known(c)) begin
                m_err = 1;
            end else begin
                if (!oexl) begin
                    m_bd  = exc_in_delay_i;
                    m_epc = exc_in_delay_i ? exc_pc_i - 64'd4 : exc_pc_i;
                end
                m_exl  = 1;
                m_ce   = cp;
                m_code = c;
                m_vec  = f_vec(c, oexl, tlb_refill_invalid_i, bad_vaddr_i,
                               user_wide_i, super_wide_i, kernel_wide_i);
                m_red  = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic idle_inputs();
        exc_req_i = 0; exc_code_i = 0; exc_cop_i = 0; exc_pc_i = 0;
        exc_in_delay_i = 0; tlb_refill_invalid_i = 0; bad_vaddr_i = 0;
        int_pending_i = 0; int_mask_i = 0; int_enable_i = 0; err_level_i = 0;
        boot_vec_i = 0; user_wide_i = 0; super_wide_i = 0; kernel_wide_i = 0;
        exl_clr_i = 0;
    endtask

    task automatic req(input string tag, input logic [4:0] c, input logic [1:0] cp,
                       input logic [63:0] pc, input logic dly);
        exc_req_i = 1; exc_code_i = c; exc_cop_i = cp; exc_pc_i = pc; exc_in_delay_i = dly;
        run_cycle(tag);
        exc_req_i = 0; exc_in_delay_i = 0;
        run_cycle(tag);  // strobe must drop, state must hold
    endtask

    task automatic clear_exl(input string tag);
        exl_clr_i = 1;
        run_cycle(tag);
        exl_clr_i = 0;
    endtask

    task automatic tlb_case(input string tag, input logic [4:0] c, input logic [1:0] reg_bits,
                            input logic inv);
        bad_vaddr_i = {reg_bits, 62'h1234_5678};
        tlb_refill_invalid_i = inv;
        req(tag, c, 2'd0, 64'h0000_0000_0040_1000, 1'b0);
        tlb_refill_invalid_i = 0;
        clear_exl("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        model_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check_state("R11");
        rst = 0;

        // R4 delay slot, general entry R6
        req("R4", 5'd8, 2'd1, 64'h0000_0000_0000_2004, 1'b1);
        // R5 nested entry keeps EPC/BD
        req("R5", 5'd12, 2'd2, 64'h0000_0000_0000_9000, 1'b0);
        clear_exl("R10");
        // R4 non-slot
        req("R4", 5'd10, 2'd3, 64'hFFFF_FFFF_8000_0040, 1'b0);
        clear_exl("R10");
        // R6 watch and FPE codes
        req("R6", 5'd23, 2'd0, 64'h100, 1'b0);
        clear_exl("R10");
        req("R6", 5'd15, 2'd1, 64'h200, 1'b1);
        clear_exl("R10");

        // R7 / R8 TLB cases
        user_wide_i = 1; super_wide_i = 1; kernel_wide_i = 0;
        tlb_case("R8", 5'd2, 2'b00, 1'b0);
        tlb_case("R8", 5'd3, 2'b01, 1'b0);
        tlb_case("R8", 5'd2, 2'b10, 1'b0);
        tlb_case("R8", 5'd3, 2'b11, 1'b0);
        kernel_wide_i = 1;
        tlb_case("R8", 5'd2, 2'b11, 1'b0);
        tlb_case("R7", 5'd2, 2'b00, 1'b1);
        // R7 miss with EXL already set goes general
        req("R7", 5'd8, 2'd0, 64'h300, 1'b0);
        bad_vaddr_i = 64'h0;
        req("R7", 5'd3, 2'd0, 64'h400, 1'b0);
        clear_exl("R10");

        // R1/R2 interrupt path
        int_mask_i = 8'h80; int_pending_i = 8'h80; int_enable_i = 1;
        exc_pc_i = 64'h0000_0000_0000_5000;
        run_cycle("R2");
        run_cycle("R1");            // gate closed at exception level
        clear_exl("R10");           // gate stays closed this cycle (old EXL=1)
        int_pending_i = 8'h00;
        run_cycle("R1");
        int_pending_i = 8'h80; err_level_i = 1;
        run_cycle("R1");
        err_level_i = 0; int_mask_i = 8'h01;
        run_cycle("R1");
        int_mask_i = 8'h80;
        req("R2", 5'd9, 2'd2, 64'h0000_0000_0000_6000, 1'b0);
        int_enable_i = 0; int_pending_i = 0;
        clear_exl("R10");

        // R9 unsupported code and bootstrap bit
        req("R9", 5'd14, 2'd1, 64'h700, 1'b0);
        boot_vec_i = 1;
        req("R9", 5'd8, 2'd1, 64'h700, 1'b0);
        boot_vec_i = 0;

        // R10 clear and entry in the same cycle
        req("R3", 5'd13, 2'd0, 64'h800, 1'b0);
        exl_clr_i = 1;
        req("R10", 5'd11, 2'd1, 64'h900, 1'b0);
        exl_clr_i = 0;

        // randomized mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0] codes [16] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,23};
            exc_req_i = ($urandom % 3) == 0;
            exc_code_i = (($urandom % 16) == 0) ? 5'($urandom % 32) : codes[$urandom % 16];
            exc_cop_i = 2'($urandom);
            exc_pc_i = {$urandom, $urandom};
            exc_in_delay_i = 1'($urandom);
            tlb_refill_invalid_i = ($urandom % 4) == 0;
            bad_vaddr_i = {$urandom, $urandom};
            int_pending_i = 8'($urandom);
            int_mask_i = 8'($urandom);
            int_enable_i = ($urandom % 4) == 0;
            err_level_i = ($urandom % 6) == 0;
            boot_vec_i = ($urandom % 20) == 0;
            user_wide_i = 1'($urandom);
            super_wide_i = 1'($urandom);
            kernel_wide_i = 1'($urandom);
            exl_clr_i = ($urandom % 3) == 0;
            run_cycle("R3");
        end
        idle_inputs();

        // R11 reset mid-run
        req("R3", 5'd4, 2'd1, 64'hA00, 1'b1);
        rst = 1;
        @(negedge clk);
        model_reset();
        rst = 0;
        check_state("R11");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule